// File: doc/BRIEF.md
# Display Frame Transfer Engine

This block moves one complete frame of display bytes from system memory to an external shift-register LCD driver, so the processor does not have to copy each byte itself. Software sets the clock-pacing choice, the first byte address of the frame buffer, and the panel size as a row count and a bytes-per-row count. It then writes a launch command. The engine computes the frame length once, at launch.

Once launched, the engine raises a bus request and waits for the processor to grant the bus. It then reads the buffer one byte at a time at consecutive addresses. For each byte it presents the value on the driver data bus and pulses a transfer strobe. The strobe is paced by one of two tick inputs, chosen by the pacing bit. After the last strobe the engine withdraws its bus request. One cycle later it raises a done pulse and returns to idle.

Top module: `lcd_frame_dma`

## Requirements
- R1: After reset, the registers hold zero and all of `bus_req`, `busy`, `mem_rd`, `lcd_strobe` and `done` are low. The register select codes are: 0 for pacing (`cfg_wdata` bit 0), 1 for the buffer address, 2 for the row count, 3 for the bytes per row, and 4 for launch (data ignored).
- R2: An accepted launch write makes `busy` and `bus_req` high in the next cycle.
- R3: `mem_rd` is never high unless `bus_ack` is high. No read is issued before the grant arrives.
- R4: Byte k of a frame is read from address base+k, with 16-bit wrap. `lcd_data` carries that byte during its strobe.
- R5: The frame length is rows times bytes-per-row, captured at launch. Size writes made during a transfer do not change the running frame.
- R6: Each byte produces exactly one `lcd_strobe` pulse, one cycle wide. `lcd_data` is stable in the strobe cycle and in the cycle before it.
- R7: Strobes are paced by `tick_slow` when the pacing bit is 0 and by `tick_timer` when it is 1. The pacing bit is read live, so a change takes effect during a transfer. While only the unselected tick toggles, no strobe occurs.
- R8: After the final strobe, `bus_req` goes low. `done` is high for exactly one cycle, in the cycle after the first cycle with `bus_req` low. `busy` then falls.
- R9: A launch write while `busy` is high is ignored. This includes a launch write in the cycle of the `done` pulse.
- R10: A launch write with a frame length of zero is ignored. `busy` and `bus_req` stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | ADDR_W | Register write data |
| tick_slow | input | 1 | Low-frequency pacing tick |
| tick_timer | input | 1 | Alternate timer pacing tick |
| bus_req | output | 1 | Bus release request to the processor |
| bus_ack | input | 1 | Bus grant from the processor |
| mem_rd | output | 1 | Memory read enable |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | DATA_W | Read data, valid the cycle after `mem_rd` |
| lcd_data | output | DATA_W | Driver data bus |
| lcd_strobe | output | 1 | Driver transfer strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two functions can fall in the same cycle: a register write, either a launch or a size change, and the closing phase of a running frame. The bench changes the row count and repeats the launch in the middle of a frame. It also writes launch in the very cycle that `done` is high. It then judges at the ports that the strobe count equals the length captured at the first launch, and that no second bus request appears. A second overlap comes from changing the pacing bit while the engine waits on the unselected tick: the frame must stall and then finish under the newly chosen tick.

// File: rtl/lcd_dma_pkg.sv
package lcd_dma_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_REQ, S_RD, S_LAT, S_WAIT, S_STB, S_LOW, S_REL, S_DONE
  } dma_state_t;

  localparam logic [2:0] SEL_PACE = 3'd0;
  localparam logic [2:0] SEL_BASE = 3'd1;
  localparam logic [2:0] SEL_ROWS = 3'd2;
  localparam logic [2:0] SEL_COLS = 3'd3;
  localparam logic [2:0] SEL_GO   = 3'd4;

  // frame length in bytes from the panel geometry
  function automatic logic [31:0] frame_words(input logic [15:0] rows,
                                               input logic [15:0] cols);
    return 32'(rows) * 32'(cols);
  endfunction

endpackage

// File: rtl/lcd_dma_regs.sv
module lcd_dma_regs
  import lcd_dma_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8,
  localparam int CNT_W = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              busy,
  output logic              pace_sel,
  output logic [ADDR_W-1:0] base,
  output logic [CNT_W-1:0]  total,
  output logic              start_go
);
  logic [DIM_W-1:0] rows_q, cols_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pace_sel <= 1'b0;
      base     <= '0;
      rows_q   <= '0;
      cols_q   <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_PACE: pace_sel <= cfg_wdata[0];
        SEL_BASE: base     <= cfg_wdata;
        SEL_ROWS: rows_q   <= cfg_wdata[DIM_W-1:0];
        SEL_COLS: cols_q   <= cfg_wdata[DIM_W-1:0];
        default:  ;
      endcase
    end
  end

  assign total    = CNT_W'(frame_words(16'(rows_q), 16'(cols_q)));
  assign start_go = cfg_we && (cfg_sel == SEL_GO) && !busy && (total != '0);
endmodule

// File: rtl/lcd_dma_addr_cnt.sv
module lcd_dma_addr_cnt #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  total,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [CNT_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= base;
      remain <= total;
    end else if (step) begin
      addr   <= addr + ADDR_W'(1);
      remain <= remain - CNT_W'(1);
    end
  end

  assign last = (remain == CNT_W'(1));
endmodule

// File: rtl/lcd_dma_seq.sv
module lcd_dma_seq
  import lcd_dma_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_go,
  input  logic bus_ack,
  input  logic pace_tick,
  input  logic last,
  output logic bus_req,
  output logic busy,
  output logic mem_rd,
  output logic lat_en,
  output logic strobe,
  output logic step,
  output logic done
);
  dma_state_t state, nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (start_go) nxt = S_REQ;
      S_REQ:   if (bus_ack) nxt = S_RD;
      S_RD:    nxt = S_LAT;
      S_LAT:   nxt = S_WAIT;
      S_WAIT:  if (pace_tick) nxt = S_STB;
      S_STB:   nxt = S_LOW;
      S_LOW:   nxt = last ? S_REL : S_RD;
      S_REL:   nxt = S_DONE;
      S_DONE:  nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  assign busy    = (state != S_IDLE);
  assign bus_req = busy && (state != S_REL) && (state != S_DONE);
  assign mem_rd  = (state == S_RD);
  assign lat_en  = (state == S_LAT);
  assign strobe  = (state == S_STB);
  assign step    = (state == S_LOW);
  assign done    = (state == S_DONE);
endmodule

// File: rtl/lcd_frame_dma.sv
module lcd_frame_dma #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int DIM_W  = 8,
  localparam int CNT_W = 2 * DIM_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [2:0]        cfg_sel,
  input  logic [ADDR_W-1:0] cfg_wdata,
  input  logic              tick_slow,
  input  logic              tick_timer,
  output logic              bus_req,
  input  logic              bus_ack,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] lcd_data,
  output logic              lcd_strobe,
  output logic              busy,
  output logic              done
);
  // named internal events, also used by the bound checker
  logic              start_go;
  logic              last_word;
  logic              step;
  logic              lat_en;
  logic              pace_sel;
  logic              pace_tick;
  logic [ADDR_W-1:0] base;
  logic [CNT_W-1:0]  total;

  lcd_dma_regs #(.ADDR_W(ADDR_W), .DIM_W(DIM_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .busy(busy), .pace_sel(pace_sel),
    .base(base), .total(total), .start_go(start_go)
  );

  lcd_dma_addr_cnt #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start_go), .base(base),
    .total(total), .step(step), .addr(mem_addr), .last(last_word)
  );

  lcd_dma_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_go(start_go), .bus_ack(bus_ack),
    .pace_tick(pace_tick), .last(last_word), .bus_req(bus_req),
    .busy(busy), .mem_rd(mem_rd), .lat_en(lat_en), .strobe(lcd_strobe),
    .step(step), .done(done)
  );

  assign pace_tick = pace_sel ? tick_timer : tick_slow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      lcd_data <= '0;
    else if (lat_en) lcd_data <= mem_rdata;
  end
endmodule

// File: rtl/lcd_frame_dma_chk.sv
module lcd_frame_dma_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_req,
  input logic              bus_ack,
  input logic              mem_rd,
  input logic              lcd_strobe,
  input logic [DATA_W-1:0] lcd_data,
  input logic              busy,
  input logic              done,
  input logic              start_go,
  input logic              last_word,
  input logic              step
);
  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_go |=> (busy && bus_req));

  // R3
  rd_needs_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (bus_ack && bus_req));

  // R6
  strobe_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_strobe |=> !lcd_strobe);

  // R6
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_strobe |-> $stable(lcd_data));

  // R8
  release_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && last_word) |=> (!bus_req && !done && busy));

  // R8
  done_after_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bus_req && !done) |=> done);

  // R8
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy));
endmodule

bind lcd_frame_dma lcd_frame_dma_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_ack(bus_ack),
  .mem_rd(mem_rd), .lcd_strobe(lcd_strobe), .lcd_data(lcd_data),
  .busy(busy), .done(done), .start_go(start_go), .last_word(last_word),
  .step(step)
);

// File: tb/lcd_frame_dma_tb.sv
module lcd_frame_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;
  localparam int DIM_W  = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [2:0]        cfg_sel = 3'd0;
  logic [ADDR_W-1:0] cfg_wdata = '0;
  logic              tick_slow = 1'b0;
  logic              tick_timer = 1'b0;
  logic              bus_req;
  logic              bus_ack = 1'b0;
  logic              mem_rd;
  logic [ADDR_W-1:0] mem_addr;
  logic [DATA_W-1:0] mem_rdata = '0;
  logic [DATA_W-1:0] lcd_data;
  logic              lcd_strobe;
  logic              busy;
  logic              done;

  lcd_frame_dma #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DIM_W(DIM_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .tick_slow(tick_slow), .tick_timer(tick_timer),
    .bus_req(bus_req), .bus_ack(bus_ack), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rdata(mem_rdata), .lcd_data(lcd_data),
    .lcd_strobe(lcd_strobe), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int nvec = 0, nfail = 0;
  int n_strobe = 0, n_done = 0, rd_viol = 0;
  int cyc = 0, ack_cnt = 0, ack_dly = 2;
  bit slow_en = 1'b0, tmr_en = 1'b0;
  logic req_d1 = 1'b0, req_d2 = 1'b0;
  logic [DATA_W-1:0] exp_q[$];

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    return 8'(a * 16'd13 + 16'd5) ^ a[15:8];
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // synchronous memory model
  always @(posedge clk) if (mem_rd) mem_rdata <= mem_byte(mem_addr);

  // ticks, grant and monitor all act at the falling edge
  always @(negedge clk) begin
    cyc++;
    tick_slow  = slow_en && (cyc % 4 == 0);
    tick_timer = tmr_en && (cyc % 3 == 0);
    if (bus_req) ack_cnt++; else ack_cnt = 0;
    bus_ack = bus_req && (ack_cnt >= ack_dly);
  end

  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_rd && !(bus_ack && bus_req)) rd_viol++;
      if (lcd_strobe) begin
        n_strobe++;
        if (exp_q.size() == 0) check(1'b0, "R5 extra strobe", 32'(lcd_data), 0);
        else begin
          logic [DATA_W-1:0] e;
          e = exp_q.pop_front();
          check(lcd_data == e, "R4 strobe data", 32'(lcd_data), 32'(e));
        end
      end
      if (done) begin
        n_done++;
        check(!bus_req && !req_d1 && req_d2, "R8 done timing",
              {29'd0, bus_req, req_d1, req_d2}, 32'b001);
      end
      req_d2 = req_d1;
      req_d1 = bus_req;
    end
  end

  task automatic cfg_write(input logic [2:0] sel, input logic [15:0] d,
                           input bit now = 1'b0);
    if (!now) @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic setup(input logic [15:0] b, input int r, input int c);
    cfg_write(3'd1, b);
    cfg_write(3'd2, 16'(r));
    cfg_write(3'd3, 16'(c));
    for (int k = 0; k < r * c; k++) exp_q.push_back(mem_byte(b + 16'(k)));
  endtask

  task automatic wait_done();
    int t;
    t = 0;
    while (!done && t < 3000) begin @(negedge clk); t++; end
    if (!done) check(1'b0, "R8 done timeout", 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    check(1'b0, "watchdog", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end

  initial begin
    int s0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check({bus_req, busy, mem_rd, lcd_strobe, done} == 5'b0, "R1 reset outputs",
          {27'd0, bus_req, busy, mem_rd, lcd_strobe, done}, 0);
    rst_n = 1'b1;

    // frame A: 2x3 from 0x0020, slow tick, mid-frame writes
    slow_en = 1'b1;
    cfg_write(3'd0, 16'd0);
    setup(16'h0020, 2, 3);
    cfg_write(3'd4, 16'd0);
    check(busy && bus_req, "R2 launch", {30'd0, busy, bus_req}, 3);
    check(!mem_rd, "R3 no read before grant", 32'(mem_rd), 0);
    while (n_strobe < 2) @(negedge clk);
    cfg_write(3'd2, 16'd9);   // R5 size change mid-frame
    cfg_write(3'd4, 16'd0);   // R9 launch while busy
    wait_done();
    cfg_write(3'd4, 16'd0, 1'b1); // R9 launch in the done cycle
    repeat (10) @(negedge clk);
    check(!busy && !bus_req, "R9 launch ignored", {30'd0, busy, bus_req}, 0);
    check(n_strobe == 6, "R5 frame length", 32'(n_strobe), 6);
    check(exp_q.size() == 0, "R5 all bytes sent", 32'(exp_q.size()), 0);

    // frame B: pacing select switched live
    slow_en = 1'b0; tmr_en = 1'b1;
    setup(16'h0100, 1, 4);
    cfg_write(3'd4, 16'd0);
    s0 = n_strobe;
    repeat (60) @(negedge clk);
    check(n_strobe == s0, "R7 unselected tick idle", 32'(n_strobe), 32'(s0));
    check(bus_req == 1'b1, "R7 still holding bus", 32'(bus_req), 1);
    cfg_write(3'd0, 16'd1);
    wait_done();
    check(n_strobe == s0 + 4, "R7 timer tick paces", 32'(n_strobe), 32'(s0 + 4));

    // frame C: single byte at top address, long grant delay
    ack_dly = 7; slow_en = 1'b1;
    setup(16'hFFFF, 1, 1);
    cfg_write(3'd4, 16'd0);
    wait_done();
    @(negedge clk);
    check(exp_q.size() == 0, "R4 single byte", 32'(exp_q.size()), 0);
    check(!busy, "R8 busy falls after done", 32'(busy), 0);

    // zero-size launch
    cfg_write(3'd2, 16'd0);
    cfg_write(3'd4, 16'd0);
    repeat (5) @(negedge clk);
    check(!busy && !bus_req, "R10 zero size ignored", {30'd0, busy, bus_req}, 0);

    check(rd_viol == 0, "R3 reads only under grant", 32'(rd_viol), 0);
    check(n_done == 3, "R8 done count", 32'(n_done), 3);
    check(n_strobe == 11, "R6 strobe total", 32'(n_strobe), 11);

    $display("== %0d vectors applied, %0d miscompares ==", nvec, nfail);
    $finish;
  end
endmodule